// File: doc/BRIEF.md
# Dual-Mode Serial Character Receiver

This block recovers characters from a serial line and queues them for a consumer. A frame starts with a low start bit, carries seven or eight data bits with the least significant bit first, may carry a parity bit, and ends with one or more high stop bits. The `tick` input carries timing from an external rate generator, and its meaning depends on the mode. In oversampled mode each rising edge of `tick` is one sixteenth of a bit period. The receiver finds the start edge and samples every bit at its centre. In bit-clock mode each rising edge of `tick` samples one bit directly. The line input passes through a two-flop synchronizer before any sample is taken.

Each character is stored in an eight-entry queue together with its own parity-error and framing-error flags. The queue drains through a valid/ready port. `out_valid` is high whenever the queue holds an entry. While `out_valid` is high and `out_ready` is low, the presented entry stays unchanged. An entry is removed only in a cycle where both signals are high. The queue never applies back-pressure to the line. A character that arrives while the queue is full is dropped, and the sticky `overrun` flag is set. Clearing `rx_en` stops reception, empties the queue and clears `overrun`. The receiver samples the mode, parity and length inputs when it detects each start bit.

Top module: `serial_rx_core`

## Requirements
- R1: While `rx_en` is low, the receiver ignores the line. One cycle with `rx_en` low empties the queue (`fifo_empty`=1, `out_valid`=0) and clears `overrun`.
- R2: With `sync_mode`=0, a low line at a `tick` rising edge is taken as a start bit. The start bit is re-sampled 8 ticks later. Each following bit is sampled 16 ticks after the one before it.
- R3: With `sync_mode`=0, if the line is high again at the start bit's mid-point sample, no character is produced and the receiver returns to waiting for a start edge.
- R4: With `sync_mode`=1, one bit is sampled at every rising edge of `tick`. A low sample while idle is the start bit, and the next edge samples data bit 0.
- R5: With `eight_bit`=0, seven data bits are received and bit 7 of `out_data` is 0. With `eight_bit`=1, eight data bits are received.
- R6: With `par_en`=1, one parity bit follows the data bits. `out_perr` is 1 when the total number of ones in the data and parity bits is odd under even parity (`par_odd`=0), or even under odd parity (`par_odd`=1).
- R7: With `par_en`=0, no parity bit is expected, `par_odd` has no effect, and `out_perr` is 0.
- R8: `out_ferr` is 1 when the first stop bit is sampled low. Frames followed by two or more stop bits are received back to back without error.
- R9: Characters leave in arrival order, and the queue holds 8 of them.
- R10: `fifo_empty` is 1 exactly when the queue holds no entry. `fifo_half` is 1 when it holds 4 or more entries.
- R11: A character that arrives while 8 entries are queued is discarded and sets `overrun`. `overrun` stays set until `rx_en` goes low.
- R12: `out_valid` is high while the queue is non-empty. While `out_valid` is high and `out_ready` is low, `out_data`, `out_perr` and `out_ferr` hold steady. One entry is removed per cycle with both `out_valid` and `out_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes the queue |
| sync_mode | input | 1 | 0 = 16x centre sampling, 1 = sample on each bit-clock edge |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| eight_bit | input | 1 | 1 = eight data bits, 0 = seven |
| tick | input | 1 | Oversample tick or bit clock; rising edge is the event |
| rxd | input | 1 | Serial line, idle high |
| out_valid | output | 1 | Queue head is valid |
| out_ready | input | 1 | Consumer accepts the head entry |
| out_data | output | 8 | Received character |
| out_perr | output | 1 | Parity error of the head entry |
| out_ferr | output | 1 | Framing error of the head entry |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_half | output | 1 | Queue holds at least half its depth |
| overrun | output | 1 | Sticky: a character was dropped on a full queue |

## Verification
The assertions check the queue's behaviour on every cycle. An entry held under back-pressure must stay stable. A push into a full queue must raise overrun. A disable must leave the queue empty. The half flag must never be set on an empty queue. On the framer side they check that seven-bit characters carry a zero bit 7 and that parity errors appear only when parity is enabled. Only the bench scenarios can show that bits are sampled at the right points. These scenarios cover random characters in both modes, glitch rejection, framing and parity errors, extra stop bits, ordering through eight entries, and the flush on disable.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic tick,
  output logic rxd_s,
  output logic tick_rise
);
  logic [STAGES-1:0] chain;
  logic              tick_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= rxd;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], rxd};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick;

  assign rxd_s     = chain[STAGES-1];
  assign tick_rise = tick & ~tick_q;
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      ev,
  input  logic      din,
  input  logic      sync_mode,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      eight_bit,
  output logic      push,
  output rx_entry_t push_entry
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 - 1;
  localparam int BW  = $clog2(CHAR_W);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [CHAR_W-1:0] sh;
  logic              c_sync, c_par, c_odd, c_eight, perr_q;
  logic              bit_ev;
  logic [CHAR_W-1:0] chr;
  logic [BW-1:0]     last_idx;

  assign bit_ev   = ev && (c_sync || cnt == CW'(OVS - 1));
  assign chr      = c_eight ? sh : {1'b0, sh[CHAR_W-1:1]};
  assign last_idx = c_eight ? BW'(CHAR_W - 1) : BW'(CHAR_W - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      sh         <= '0;
      c_sync     <= 1'b0;
      c_par      <= 1'b0;
      c_odd      <= 1'b0;
      c_eight    <= 1'b0;
      perr_q     <= 1'b0;
      push       <= 1'b0;
      push_entry <= '0;
    end else begin
      push <= 1'b0;
      if (!en) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else begin
        if (ev && !c_sync && (state == S_DATA || state == S_PAR || state == S_STOP))
          cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
        case (state)
          S_IDLE: begin
            if (ev && !din) begin
              c_sync  <= sync_mode;
              c_par   <= par_en;
              c_odd   <= par_odd;
              c_eight <= eight_bit;
              perr_q  <= 1'b0;
              cnt     <= '0;
              bidx    <= '0;
              state   <= sync_mode ? S_DATA : S_START;
            end
          end
          S_START: begin
            if (ev) begin
              if (cnt == CW'(MID)) begin
                cnt   <= '0;
                state <= din ? S_IDLE : S_DATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_DATA: begin
            if (bit_ev) begin
              sh   <= {din, sh[CHAR_W-1:1]};
              bidx <= bidx + 1'b1;
              if (bidx == last_idx) state <= c_par ? S_PAR : S_STOP;
            end
          end
          S_PAR: begin
            if (bit_ev) begin
              perr_q <= (^chr) ^ din ^ c_odd;
              state  <= S_STOP;
            end
          end
          S_STOP: begin
            if (bit_ev) begin
              push            <= 1'b1;
              push_entry.ferr <= ~din;
              push_entry.perr <= perr_q;
              push_entry.data <= chr;
              state           <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R5
  seven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !c_eight) |-> !push_entry.data[CHAR_W-1]);

  // R7
  no_parity_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !c_par) |-> !push_entry.perr);

  // R3
  start_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == S_START && ev && cnt == CW'(MID) && din) |=> (state == S_IDLE && !push));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t wdata,
  input  logic      pop,
  output rx_entry_t rdata,
  output logic      empty,
  output logic      half,
  output logic      ovr
);
  localparam int AW = $clog2(DEPTH);

  rx_entry_t   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_pop, do_push, full;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign half    = (count >= (AW+1)'(DEPTH / 2));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      if (push && !do_push) ovr <= 1'b1;
    end
  end

  // R11
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push && count == (AW+1)'(DEPTH) && !pop) |=> ovr);

  // R1
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !ovr));

  // R10
  half_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> !empty);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              sync_mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              eight_bit,
  input  logic              tick,
  input  logic              rxd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              fifo_empty,
  output logic              fifo_half,
  output logic              overrun
);
  logic      rxd_s, tick_rise, push;
  rx_entry_t push_entry, head;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd       (rxd),
    .tick      (tick),
    .rxd_s     (rxd_s),
    .tick_rise (tick_rise)
  );

  srx_framer #(.OVS(OVS)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rx_en),
    .ev         (tick_rise),
    .din        (rxd_s),
    .sync_mode  (sync_mode),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .eight_bit  (eight_bit),
    .push       (push),
    .push_entry (push_entry)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!rx_en),
    .push  (push),
    .wdata (push_entry),
    .pop   (out_ready),
    .rdata (head),
    .empty (fifo_empty),
    .half  (fifo_half),
    .ovr   (overrun)
  );

  assign out_valid = !fifo_empty;
  assign out_data  = head.data;
  assign out_perr  = head.perr;
  assign out_ferr  = head.ferr;

  // R12
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                            && $stable(out_perr) && $stable(out_ferr)));
endmodule

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
  logic       clk = 1'b0;
  logic       rst_n, rx_en, sync_mode, par_en, par_odd, eight_bit, tick, rxd, out_ready;
  logic       out_valid, out_perr, out_ferr, fifo_empty, fifo_half, overrun;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  serial_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sync_mode(sync_mode), .par_en(par_en),
    .par_odd(par_odd), .eight_bit(eight_bit), .tick(tick), .rxd(rxd),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .fifo_empty(fifo_empty),
    .fifo_half(fifo_half), .overrun(overrun)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  int         cyc   = 0;
  bit         finished = 0;
  logic [9:0] expq [64];
  int         qh = 0;
  int         qt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_entry(input logic [7:0] d, input bit eb, input bit pe,
                                           input bit badp, input bit bads);
    return {bads, pe & badp, eb ? d : {1'b0, d[6:0]}};
  endfunction

  task automatic tick16(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit sm, input bit eb, input bit pe,
                            input bit od, input int nstop, input bit badp, input bit bads,
                            input bit record);
    logic [15:0] fb;
    int          nb;
    fb = '1;
    nb = 0;
    sync_mode = sm; eight_bit = eb; par_en = pe; par_odd = od;
    fb[nb] = 1'b0; nb++;
    for (int i = 0; i < (eb ? 8 : 7); i++) begin fb[nb] = d[i]; nb++; end
    if (pe) begin fb[nb] = (eb ? ^d : ^d[6:0]) ^ od ^ badp; nb++; end
    for (int i = 0; i < nstop; i++) begin fb[nb] = (i == 0) ? ~bads : 1'b1; nb++; end
    if (!sm) begin
      tick16(2);
      for (int i = 0; i < nb; i++) begin rxd = fb[i]; tick16(16); end
      rxd = 1'b1;
      tick16(12);
    end else begin
      for (int i = 0; i < nb; i++) begin
        rxd = fb[i];
        tick = 1'b0; repeat (8) @(negedge clk);
        tick = 1'b1; repeat (8) @(negedge clk);
      end
      rxd = 1'b1;
      tick = 1'b0; repeat (6) @(negedge clk);
    end
    if (record) begin
      expq[qt % 64] = exp_entry(d, eb, pe, badp, bads);
      qt++;
    end
  endtask

  task automatic pop_check(input string tag);
    int w;
    w = 0;
    while (!out_valid && w < 2000) begin @(negedge clk); w++; end
    chk(tag, {22'd0, out_ferr, out_perr, out_data}, {22'd0, expq[qh % 64]});
    qh++;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      summary();
    end
  end

  initial begin
    logic [7:0] hold_d;
    void'($urandom(32'h00C0FFEE));
    rst_n = 0; rx_en = 0; sync_mode = 0; par_en = 0; par_odd = 0; eight_bit = 1;
    tick = 0; rxd = 1; out_ready = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset empty", fifo_empty, 1);
    chk("R12 reset valid", out_valid, 0);
    chk("R10 reset half", fifo_half, 0);
    chk("R11 reset overrun", overrun, 0);

    // R1: disabled receiver ignores a full frame
    send_frame(8'hA5, 0, 1, 0, 0, 1, 0, 0, 0);
    chk("R1 ignore while disabled", fifo_empty, 1);
    rx_en = 1;
    @(negedge clk);

    // R2 R5 R6 R7 R8: random frames in 16x mode
    for (int i = 0; i < 16; i++) begin
      send_frame(8'($urandom), 0, 1'($urandom), 1'($urandom), 1'($urandom),
                 1 + int'($urandom % 2), 1'($urandom % 4 == 0), 1'($urandom % 5 == 0), 1);
      pop_check("R2 random 16x frame");
    end
    // R4: random frames in bit-clock mode
    for (int i = 0; i < 24; i++) begin
      send_frame(8'($urandom), 1, 1'($urandom), 1'($urandom), 1'($urandom),
                 1 + int'($urandom % 2), 1'($urandom % 4 == 0), 1'($urandom % 5 == 0), 1);
      pop_check("R4 random 1x frame");
    end

    // R5 directed
    send_frame(8'hFF, 0, 0, 0, 0, 1, 0, 0, 1);
    pop_check("R5 seven-bit forces bit7 low");
    // R6 directed
    send_frame(8'h3C, 1, 1, 1, 0, 1, 1, 0, 1);
    pop_check("R6 even parity mismatch");
    send_frame(8'h81, 0, 1, 1, 1, 1, 0, 0, 1);
    pop_check("R6 odd parity match");
    // R7 directed: odd select with parity off
    send_frame(8'h5A, 0, 1, 0, 1, 1, 0, 0, 1);
    pop_check("R7 odd ignored, parity off");
    // R8 directed
    send_frame(8'h99, 0, 1, 0, 0, 1, 0, 1, 1);
    pop_check("R8 low stop bit");
    send_frame(8'h12, 0, 1, 1, 0, 2, 0, 0, 1);
    send_frame(8'h34, 0, 1, 1, 0, 2, 0, 0, 1);
    pop_check("R8 two stop bits first");
    pop_check("R8 two stop bits second");

    // R3: short low pulse in 16x mode
    sync_mode = 0;
    rxd = 0; tick16(3);
    rxd = 1; tick16(40);
    chk("R3 glitch rejected", fifo_empty, 1);
    send_frame(8'h6E, 0, 1, 0, 0, 1, 0, 0, 1);
    pop_check("R3 frame after glitch");

    // R12: stall holds head
    send_frame(8'hC3, 1, 1, 0, 0, 1, 0, 0, 1);
    @(negedge clk);
    hold_d = out_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R12 valid held under stall", out_valid, 1);
      chk("R12 data held under stall", out_data, hold_d);
    end
    pop_check("R12 stalled entry");

    // R9 R10 R11: fill past depth in bit-clock mode
    for (int i = 0; i < 9; i++) begin
      send_frame(8'(8'h40 + i), 1, 1, 0, 0, 1, 0, 0, 1);
      if (i == 2) chk("R10 half low at 3", fifo_half, 0);
      if (i == 3) chk("R10 half high at 4", fifo_half, 1);
      if (i == 7) chk("R11 no overrun at 8", overrun, 0);
    end
    chk("R11 overrun on ninth", overrun, 1);
    for (int i = 0; i < 8; i++) pop_check("R9 order through depth");
    qh++;
    chk("R10 empty after drain", fifo_empty, 1);
    chk("R11 overrun sticky", overrun, 1);
    rx_en = 0; @(negedge clk); @(negedge clk); rx_en = 1; @(negedge clk);
    chk("R1 overrun cleared by disable", overrun, 0);

    // R1: flush of queued entries
    send_frame(8'h11, 1, 1, 0, 0, 1, 0, 0, 1);
    send_frame(8'h22, 1, 1, 0, 0, 1, 0, 0, 1);
    chk("R10 two entries not empty", fifo_empty, 0);
    rx_en = 0; @(negedge clk); @(negedge clk); rx_en = 1; @(negedge clk);
    qh += 2;
    chk("R1 flush empties queue", fifo_empty, 1);
    chk("R1 flush drops valid", out_valid, 0);
    send_frame(8'h77, 0, 0, 1, 1, 1, 0, 0, 1);
    pop_check("R1 reception after re-enable");

    summary();
  end
endmodule